// File: doc/BRIEF.md
# Coprocessor Instruction Cache Line Tracker

This block keeps the bookkeeping for a 512-byte instruction cache in a graphics coprocessor. The cache is split into 32 lines of 16 bytes. A host fills the cache by writing bytes into it. The tracker does not store the code bytes. It keeps one valid flag per line, holds the line-aligned base address of the cached region, and keeps an active flag.

A lookup port takes a 16-bit program counter. It reports a hit when the cache is active and the counter lies in the 512-byte window that starts at the base. A line is marked valid only when its final byte arrives, so a partly filled line never counts as valid. A flush pulse, or loading a different base address, discards all the line flags.

Top module: `icache_line_tracker`

## Requirements
- R1: A host write whose offset has bits 3:0 equal to 4'hF sets `line_valid[offset[8:4]]` on the next clock edge. Each of the 32 lines can be set this way.
- R2: A host write to any offset whose bits 3:0 are not 4'hF leaves `line_valid` unchanged.
- R3: A flush pulse clears all 32 flags, the base register and `cache_active` on the next edge. Afterwards a base load of 0x0000 is treated as an unchanged base.
- R4: `pc_hit` is 1 exactly when `cache_active` is 1 and base <= pc < base + 512. The window does not wrap past 0xFFFF, so with base 0xFFF0 a pc of 0x0005 misses.
- R5: A base load forces bits 3:0 of the stored base to zero. For example, a load of 0x1237 stores 0x1230.
- R6: A base load whose aligned value differs from the stored base does three things on the next edge: it stores the new base, clears all line flags and sets `cache_active`.
- R7: A base load whose aligned value equals the stored base changes nothing. Flags, base and `cache_active` all keep their values.
- R8: While `rst_n` is low at a clock edge, the block enters the same state a flush produces: no valid lines, base 0, inactive.
- R9: A flush in the same cycle as a host write or a base load wins. The write and the load are dropped.
- R10: A base change in the same cycle as a last-byte write clears all flags. That write sets nothing.
- R11: `pc_hit` follows a change of `pc` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte-write strobe into the cache window |
| host_off | input | 9 | Byte offset of the write inside the cache |
| flush | input | 1 | Flush pulse |
| base_ld | input | 1 | Base register load strobe |
| base_val | input | 16 | Value offered to the base register |
| pc | input | 16 | Program counter to look up |
| line_valid | output | 32 | One valid flag per cache line |
| cache_active | output | 1 | Cache is active |
| pc_hit | output | 1 | Program counter lies in the active cached window |

## Verification
The assertions assume that the strobes are well-defined 0/1 values on every clock edge after reset. They also assume that `host_off` and `base_val` are stable whenever their strobes are high. Nothing is assumed about how the strobes overlap, because the priorities are part of the design. The stimulus changes inputs only on falling clock edges and deasserts each strobe after the cycle it is used. It combines flush, base load and writes in the same cycle on purpose so that every priority rule fires.

// File: rtl/icache_trk_pkg.sv
// Package: shared geometry of the instruction cache tracker.
// Assumes a power-of-two line size and line count.
package icache_trk_pkg;
    localparam int LINE_LOG2  = 4;   // 16 bytes per line
    localparam int LINES_LOG2 = 5;   // 32 lines
    localparam int ADDR_W     = 16;  // program counter / base width
endpackage

// File: rtl/icache_valid_flags.sv
// Line valid flag array. A write to the final byte of a line marks that line
// valid. A clear request (a flush or a base change) empties the whole array
// and takes priority over a write in the same cycle.
// Assumes: wr_off is stable while wr_en is high.
module icache_valid_flags #(
    parameter int LINE_LOG2  = icache_trk_pkg::LINE_LOG2,
    parameter int LINES_LOG2 = icache_trk_pkg::LINES_LOG2,
    localparam int NLINES    = 1 << LINES_LOG2,
    localparam int OFF_W     = LINE_LOG2 + LINES_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              clr,
    output logic [NLINES-1:0] vld_q
);
    logic last_byte;
    logic [LINES_LOG2-1:0] line_sel;

    // Detect a write to the final byte of a line.
    assign last_byte = wr_en && (&wr_off[LINE_LOG2-1:0]);
    assign line_sel  = wr_off[OFF_W-1:LINE_LOG2];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // One flag per line: cleared by reset or clear, set by its last byte.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                vld_q[g] <= 1'b0;
            else if (last_byte && (line_sel == LINES_LOG2'(g)))
                vld_q[g] <= 1'b1;
        end
    end

    p_last_byte_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_off[LINE_LOG2-1:0]) && !clr)
        |=> vld_q[$past(wr_off[OFF_W-1:LINE_LOG2])]);

    p_other_bytes_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(wr_en && (&wr_off[LINE_LOG2-1:0]))) |=> $stable(vld_q));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));
endmodule

// File: rtl/icache_base_reg.sv
// Cache base register and active flag. A load is aligned to a line boundary.
// A load that changes the base sets the active flag and raises base_chg so
// the line flags are cleared. A flush zeroes the base, drops the active flag
// and overrides any load in the same cycle.
// Assumes: base_val is stable while base_ld is high.
module icache_base_reg #(
    parameter int LINE_LOG2 = icache_trk_pkg::LINE_LOG2,
    parameter int ADDR_W    = icache_trk_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              base_ld,
    input  logic [ADDR_W-1:0] base_val,
    output logic [ADDR_W-1:0] base_q,
    output logic              active_q,
    output logic              base_chg
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << LINE_LOG2) - 1);

    logic [ADDR_W-1:0] aligned;

    // Force the offered value onto a line boundary.
    assign aligned  = base_val & ALIGN_MASK;
    // A load counts only if it changes the base and no flush competes.
    assign base_chg = base_ld && !flush && (aligned != base_q);

    // Base and active state: reset and flush clear them, a changing load sets them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            base_q   <= '0;
            active_q <= 1'b0;
        end else if (base_chg) begin
            base_q   <= aligned;
            active_q <= 1'b1;
        end
    end

    p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[LINE_LOG2-1:0] == '0);

    p_new_base_activates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        base_chg |=> (active_q && (base_q == ($past(base_val) & ALIGN_MASK))));

    p_same_base_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !base_chg) |=> ($stable(base_q) && $stable(active_q)));

    p_flush_clears_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (base_q == '0 && !active_q));
endmodule

// File: rtl/icache_hit_cmp.sv
// Window comparator. It reports whether pc lies in [base, base + window).
// The compare is one bit wider than the address, so the window never wraps.
// It is purely combinational.
module icache_hit_cmp #(
    parameter int ADDR_W   = icache_trk_pkg::ADDR_W,
    parameter int WIN_LOG2 = icache_trk_pkg::LINE_LOG2 + icache_trk_pkg::LINES_LOG2
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pc,
    output logic              hit
);
    logic [ADDR_W:0] lo, hi, pcx;

    // Widen the operands so base + window cannot overflow.
    assign lo  = {1'b0, base};
    assign hi  = lo + (ADDR_W+1)'(1 << WIN_LOG2);
    assign pcx = {1'b0, pc};
    assign hit = active && (pcx >= lo) && (pcx < hi);
endmodule

// File: rtl/icache_line_tracker.sv
// Top of the instruction cache tracker. It ties together the base register,
// the line flag array and the window comparator. Data storage lives elsewhere.
// Assumes: a synchronous active-low reset and a single clock.
module icache_line_tracker #(
    parameter int LINE_LOG2  = icache_trk_pkg::LINE_LOG2,
    parameter int LINES_LOG2 = icache_trk_pkg::LINES_LOG2,
    parameter int ADDR_W     = icache_trk_pkg::ADDR_W,
    localparam int NLINES    = 1 << LINES_LOG2,
    localparam int OFF_W     = LINE_LOG2 + LINES_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic              flush,
    input  logic              base_ld,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] pc,
    output logic [NLINES-1:0] line_valid,
    output logic              cache_active,
    output logic              pc_hit
);
    logic [ADDR_W-1:0] base_q;
    logic              base_chg;
    logic              clr_all;

    // A flush or a base change empties the line flags.
    assign clr_all = flush || base_chg;

    icache_base_reg #(.LINE_LOG2(LINE_LOG2), .ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst_n(rst_n), .flush(flush), .base_ld(base_ld),
        .base_val(base_val), .base_q(base_q), .active_q(cache_active),
        .base_chg(base_chg)
    );

    icache_valid_flags #(.LINE_LOG2(LINE_LOG2), .LINES_LOG2(LINES_LOG2)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_off(host_off),
        .clr(clr_all), .vld_q(line_valid)
    );

    icache_hit_cmp #(.ADDR_W(ADDR_W), .WIN_LOG2(OFF_W)) u_cmp (
        .active(cache_active), .base(base_q), .pc(pc), .hit(pc_hit)
    );

    p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (line_valid == '0 && !cache_active));

    p_hit_needs_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |-> cache_active);

    p_reset_state_r8: assert property (@(posedge clk)
        !rst_n |=> (line_valid == '0 && !cache_active && !pc_hit));
endmodule

// File: tb/icache_line_tracker_tb_top.sv
module icache_line_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [8:0]  host_off = '0;
    logic        flush = 1'b0;
    logic        base_ld = 1'b0;
    logic [15:0] base_val = '0;
    logic [15:0] pc = '0;
    logic [31:0] line_valid;
    logic        cache_active;
    logic        pc_hit;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    icache_line_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_off(host_off),
        .flush(flush), .base_ld(base_ld), .base_val(base_val), .pc(pc),
        .line_valid(line_valid), .cache_active(cache_active), .pc_hit(pc_hit)
    );

    typedef struct packed {
        logic        wr;
        logic [8:0]  off;
        logic        fl;
        logic        ld;
        logic [15:0] val;
        logic [15:0] pc;
        logic [31:0] ev;
        logic        ea;
        logic        eh;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R5 R6: load 0x1237 -> base 0x1230, active, pc at base hits
        '{1'b0, 9'h000, 1'b0, 1'b1, 16'h1237, 16'h1230, 32'h0000_0000, 1'b1, 1'b1},
        // R1: last byte of line 0; R4: pc one below base misses
        '{1'b1, 9'h00F, 1'b0, 1'b0, 16'h0000, 16'h122F, 32'h0000_0001, 1'b1, 1'b0},
        // R2: non-final byte ignored; R4: last byte of window hits
        '{1'b1, 9'h1F5, 1'b0, 1'b0, 16'h0000, 16'h142F, 32'h0000_0001, 1'b1, 1'b1},
        // R1: line 31; R4: first byte past window misses
        '{1'b1, 9'h1FF, 1'b0, 1'b0, 16'h0000, 16'h1430, 32'h8000_0001, 1'b1, 1'b0},
        // R7: same aligned base reloaded, flags kept
        '{1'b0, 9'h000, 1'b0, 1'b1, 16'h123A, 16'h1300, 32'h8000_0001, 1'b1, 1'b1},
        // R10: base change plus last-byte write, clear wins; R4 no wrap
        '{1'b1, 9'h02F, 1'b0, 1'b1, 16'hFFF5, 16'h0005, 32'h0000_0000, 1'b1, 1'b0},
        // R1: line 2 at high base; R4: top address hits
        '{1'b1, 9'h02F, 1'b0, 1'b0, 16'h0000, 16'hFFFF, 32'h0000_0004, 1'b1, 1'b1},
        // R9 R3: flush beats write and load
        '{1'b1, 9'h03F, 1'b1, 1'b1, 16'h4000, 16'hFFF0, 32'h0000_0000, 1'b0, 1'b0},
        // R3: base is zero, so loading 0 changes nothing
        '{1'b0, 9'h000, 1'b0, 1'b1, 16'h0000, 16'h0000, 32'h0000_0000, 1'b0, 1'b0},
        // R1: flags set even while inactive; R4 inactive never hits
        '{1'b1, 9'h0FF, 1'b0, 1'b0, 16'h0000, 16'h0000, 32'h0000_8000, 1'b0, 1'b0},
        // R7: 0x0008 aligns to 0, unchanged
        '{1'b0, 9'h000, 1'b0, 1'b1, 16'h0008, 16'h0000, 32'h0000_8000, 1'b0, 1'b0},
        // R6: new base 0x0010 clears flags; R4: 0x020F hits
        '{1'b0, 9'h000, 1'b0, 1'b1, 16'h0010, 16'h020F, 32'h0000_0000, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 1'b0; flush = 1'b0; base_ld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid", line_valid, 32'h0);
        check("R8 active", {31'b0, cache_active}, 32'h0);
        pc = 16'h0000;
        #1 check("R8 hit", {31'b0, pc_hit}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            host_wr = VECS[i].wr; host_off = VECS[i].off; flush = VECS[i].fl;
            base_ld = VECS[i].ld; base_val = VECS[i].val; pc = VECS[i].pc;
            @(negedge clk);
            idle();
            check($sformatf("vec%0d valid R1/R2/R6/R7/R9/R10", i), line_valid, VECS[i].ev);
            check($sformatf("vec%0d active R3/R6/R7", i), {31'b0, cache_active}, {31'b0, VECS[i].ea});
            check($sformatf("vec%0d hit R4", i), {31'b0, pc_hit}, {31'b0, VECS[i].eh});
        end

        // R11: hit follows pc with no clock (base 0x0010 active)
        pc = 16'h0210;
        #1 check("R11 miss same cycle", {31'b0, pc_hit}, 32'h0);
        pc = 16'h0010;
        #1 check("R11 hit same cycle", {31'b0, pc_hit}, 32'h1);
        pc = 16'h000F;
        #1 check("R4 below base", {31'b0, pc_hit}, 32'h0);

        // R1: fill every line by its final byte
        for (int l = 0; l < 32; l++) begin
            host_wr = 1'b1; host_off = {l[4:0], 4'hF};
            @(negedge clk);
        end
        idle();
        check("R1 all lines", line_valid, 32'hFFFF_FFFF);

        // R2: every non-final byte of line 3 after a flush sets nothing
        flush = 1'b1;
        @(negedge clk);
        idle();
        for (int b = 0; b < 15; b++) begin
            host_wr = 1'b1; host_off = {5'd3, b[3:0]};
            @(negedge clk);
        end
        idle();
        check("R2 partial line", line_valid, 32'h0);

        // R8: reset mid-run clears state like a flush
        base_ld = 1'b1; base_val = 16'h2000; host_wr = 1'b0;
        @(negedge clk);
        idle();
        host_wr = 1'b1; host_off = 9'h01F;
        @(negedge clk);
        idle();
        check("R8 pre-reset valid", line_valid, 32'h2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R8 reset valid", line_valid, 32'h0);
        check("R8 reset active", {31'b0, cache_active}, 32'h0);
        pc = 16'h2000;
        #1 check("R8 reset hit", {31'b0, pc_hit}, 32'h0);

        @(negedge clk);
        finish_run();
    end
endmodule